// File: doc/BRIEF.md
# Bit-Serial DRAM Delay Line Controller

This controller turns a one-bit-wide dynamic RAM with a multiplexed address bus into a very long first-in, first-out delay for a serial bit stream. A binary sample counter names one memory location per sample. Each sample takes a fixed nine-clock access. In that access the controller opens the row, opens the column, latches the bit stored there, and then overwrites that bit with the new input bit. The bit read back was written exactly one full memory pass earlier, so the delay equals the number of locations in use.

The low half of the counter is sent as the row address. Because of this, every row is opened within a short run of consecutive samples, and the sweep refreshes the array with no extra refresh cycles. The write strobe fires once per sample, and a single-cycle sample strobe is issued at the same time, so external serial converters can be clocked at one ninth of the controller clock. A static mode input drops the top address line. This serves a part with one address line fewer, and the counter then wraps at a quarter of the full depth. Several parts can share the address and strobe outputs and be chained, with each part's data input taken from the previous part's data output.

Top module: `dly_line_ctrl`

## Requirements
- R1: While reset is asserted and until the first access begins, the row, column and write strobes are high, the delayed output is 0 and the sample strobe is 0.
- R2: In full mode (mode input 0), with bus width B, the row address is counter bits [B-1:0] and the column address is counter bits [2B-1:B]. The counter starts at 0 after reset, advances by one per access and wraps after 2^(2B) accesses.
- R3: In reduced mode (mode input 1), the row address is counter bits [B-2:0] and the column address is counter bits [2B-3:B-1], and the top address line is driven 0. The counter wraps after 2^(2B-2) accesses.
- R4: Within an access the row strobe falls before the column strobe. The column strobe is low only while the row strobe is low, and the write strobe is low only while both are low. After the row strobe rises, all three strobes stay high for at least one further clock.
- R5: Every access lasts exactly 9 clocks and produces one sample-strobe pulse of one clock. That pulse coincides with the write strobe being low.
- R6: The delayed output changes only in the clock in which the sample strobe rises, and it then shows the bit the memory returned in that access.
- R7: A bit presented at the input during an access reappears on the delayed output one full memory pass later: 2^(2B) accesses in full mode and 2^(2B-2) accesses in reduced mode.
- R8: The write in each access goes to the same row and column that were read in that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| small_mode | input | 1 | 1 selects the reduced memory with one address line fewer; change only under reset |
| din | input | 1 | Serial input bit, sampled once per access |
| ram_dout | input | 1 | Data output of the memory |
| ram_addr | output | BUS_W | Multiplexed row/column address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write strobe, active low; doubles as the sample clock |
| ram_din | output | 1 | Bit written into the memory |
| dout | output | 1 | Delayed serial output bit |
| sample_stb | output | 1 | One-clock pulse per access |

## Verification
The bench builds the controller with a bus width of 5 instead of 9. This shrinks one memory pass to 1024 accesses in full mode and 256 in reduced mode. As a result, a random stream can be followed through more than a full wrap of the counter in both modes, and both wrap points and the full delay are compared bit for bit. A behavioural memory model in the bench latches the row and column on the strobe edges, so address splitting, the zeroed top line and read/write location identity are observed directly at the pins.

// File: rtl/dly_pkg.sv
package dly_pkg;
    localparam int CYC_LEN = 9;
    localparam int PH_W    = $clog2(CYC_LEN);

    localparam logic [PH_W-1:0] PH_ROW  = PH_W'(0);
    localparam logic [PH_W-1:0] PH_RAS  = PH_W'(1);
    localparam logic [PH_W-1:0] PH_COL  = PH_W'(2);
    localparam logic [PH_W-1:0] PH_CAS  = PH_W'(3);
    localparam logic [PH_W-1:0] PH_CAPT = PH_W'(4);
    localparam logic [PH_W-1:0] PH_WR   = PH_W'(5);
    localparam logic [PH_W-1:0] PH_REL  = PH_W'(6);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic stb;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, stb: 1'b0};
endpackage

// File: rtl/dly_phase_seq.sv
module dly_phase_seq
    import dly_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic            sample_stb
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
        strobe_t         s;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        seq_d.ph = (seq_q.ph == PH_LAST) ? '0 : seq_q.ph + PH_W'(1);
        seq_d.s  = STROBE_IDLE;
        unique case (seq_d.ph)
            PH_RAS, PH_COL: seq_d.s.ras_n = 1'b0;
            PH_CAS, PH_CAPT: begin
                seq_d.s.ras_n = 1'b0;
                seq_d.s.cas_n = 1'b0;
            end
            PH_WR: begin
                seq_d.s.ras_n = 1'b0;
                seq_d.s.cas_n = 1'b0;
                seq_d.s.we_n  = 1'b0;
                seq_d.s.stb   = 1'b1;
            end
            default: seq_d.s = STROBE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph <= PH_LAST;
            seq_q.s  <= STROBE_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase      = seq_q.ph;
    assign ras_n      = seq_q.s.ras_n;
    assign cas_n      = seq_q.s.cas_n;
    assign we_n       = seq_q.s.we_n;
    assign sample_stb = seq_q.s.stb;

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(seq_q.ph) < CYC_LEN);
    assert_cas_under_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> !ras_n);
    assert_we_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ras_n && !cas_n));
    assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> (ras_n && cas_n && we_n));
    assert_stb_with_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> !we_n);
    assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);
endmodule

// File: rtl/dly_addr_gen.sv
module dly_addr_gen #(
    parameter int BUS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             small_mode,
    input  logic             advance,
    input  logic             col_sel,
    output logic [BUS_W-1:0] addr
);
    localparam int CNT_W = 2 * BUS_W;
    localparam int SW    = BUS_W - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] wrap_mask;
    logic [BUS_W-1:0] row_full, col_full, row_small, col_small;

    assign wrap_mask = small_mode ? {2'b00, {(2*SW){1'b1}}} : {CNT_W{1'b1}};

    always_comb begin
        cnt_d = cnt_q;
        if (advance) begin
            cnt_d = (cnt_q + CNT_W'(1)) & wrap_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign row_full  = cnt_q[BUS_W-1:0];
    assign col_full  = cnt_q[CNT_W-1:BUS_W];
    assign row_small = {1'b0, cnt_q[SW-1:0]};
    assign col_small = {1'b0, cnt_q[2*SW-1:SW]};

    always_comb begin
        if (small_mode) addr = col_sel ? col_small : row_small;
        else            addr = col_sel ? col_full  : row_full;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> cnt_q == (($past(cnt_q) + CNT_W'(1)) & $past(wrap_mask)));
    assert_small_top_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        small_mode |-> !addr[BUS_W-1]);
endmodule

// File: rtl/dly_data_path.sv
module dly_data_path (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic din,
    input  logic ram_dout,
    output logic dout,
    output logic ram_din
);
    typedef struct packed {
        logic rd;
        logic wr;
    } dat_t;

    dat_t dat_d, dat_q;

    always_comb begin
        dat_d = dat_q;
        if (capture) begin
            dat_d.rd = ram_dout;
            dat_d.wr = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dat_q <= '0;
        else        dat_q <= dat_d;
    end

    assign dout    = dat_q.rd;
    assign ram_din = dat_q.wr;

    assert_out_only_on_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(capture));
endmodule

// File: rtl/dly_line_ctrl.sv
module dly_line_ctrl
    import dly_pkg::*;
#(
    parameter int BUS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             small_mode,
    input  logic             din,
    input  logic             ram_dout,
    output logic [BUS_W-1:0] ram_addr,
    output logic             ram_ras_n,
    output logic             ram_cas_n,
    output logic             ram_we_n,
    output logic             ram_din,
    output logic             dout,
    output logic             sample_stb
);
    logic [PH_W-1:0] phase;
    logic            capture, advance, col_sel;

    dly_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .ras_n      (ram_ras_n),
        .cas_n      (ram_cas_n),
        .we_n       (ram_we_n),
        .sample_stb (sample_stb)
    );

    assign capture = (phase == PH_CAPT);
    assign advance = (phase == PH_REL);
    assign col_sel = (phase >= PH_COL) && (phase <= PH_REL);

    dly_addr_gen #(.BUS_W(BUS_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .small_mode (small_mode),
        .advance    (advance),
        .col_sel    (col_sel),
        .addr       (ram_addr)
    );

    dly_data_path u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .din      (din),
        .ram_dout (ram_dout),
        .dout     (dout),
        .ram_din  (ram_din)
    );

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cas_n && !$fell(ram_cas_n)) |-> $stable(ram_addr));
endmodule

// File: tb/tb_dly_line_ctrl.sv
`timescale 1ns/1ps
module tb_dly_line_ctrl;
    localparam int B     = 5;
    localparam int MEMSZ = 1 << (2 * B);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         small_mode = 1'b0;
    logic         din = 1'b0;
    logic         ram_dout;
    logic [B-1:0] ram_addr;
    logic         ram_ras_n, ram_cas_n, ram_we_n, ram_din, dout, sample_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dly_line_ctrl #(.BUS_W(B)) dut (
        .clk(clk), .rst_n(rst_n), .small_mode(small_mode), .din(din),
        .ram_dout(ram_dout), .ram_addr(ram_addr), .ram_ras_n(ram_ras_n),
        .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n), .ram_din(ram_din),
        .dout(dout), .sample_stb(sample_stb)
    );

    // behavioural multiplexed-address memory
    logic           mem [MEMSZ];
    logic [B-1:0]   row_l = '0, col_l = '0;
    logic [2*B-1:0] rd_loc = '0, wr_loc = '0;
    logic           prev_ras = 1'b1, prev_cas = 1'b1, mdout = 1'b0;
    assign ram_dout = mdout;

    always @(negedge clk) begin
        if (prev_ras && !ram_ras_n) row_l = ram_addr;
        if (prev_cas && !ram_cas_n) begin
            col_l  = ram_addr;
            rd_loc = {col_l, row_l};
            mdout  = mem[rd_loc];
        end
        if (!ram_we_n && !ram_cas_n) begin
            wr_loc      = {col_l, row_l};
            mem[wr_loc] = ram_din;
        end
        prev_ras = ram_ras_n;
        prev_cas = ram_cas_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_loc(input int k, input bit sm);
        int r, c;
        if (!sm) return k % MEMSZ;
        r = k % (1 << (B - 1));
        c = (k >> (B - 1)) % (1 << (B - 1));
        return (c << B) | r;
    endfunction

    bit exp_q[$];

    task automatic run_mode(input bit sm);
        int n, k, last_clk, clk_cnt;
        bit prev_dout, e;
        n = sm ? (1 << (2 * B - 2)) : MEMSZ;
        rst_n = 1'b0;
        small_mode = sm;
        din = 1'b0;
        for (int i = 0; i < MEMSZ; i++) mem[i] = 1'b0;
        exp_q.delete();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(ram_ras_n && ram_cas_n && ram_we_n, "R1 strobes idle", {ram_ras_n, ram_cas_n, ram_we_n}, 7);
        check(dout == 1'b0 && sample_stb == 1'b0, "R1 outputs low", {dout, sample_stb}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) exp_q.push_back(1'b0);
        k = 0; last_clk = 0; clk_cnt = 0; prev_dout = 1'b0;
        while (k < n + 300) begin
            @(negedge clk); #1;
            clk_cnt++;
            if (!ram_cas_n)
                check(!ram_ras_n, "R4 cas under ras", ram_ras_n, 0);
            if (!ram_we_n)
                check(!ram_ras_n && !ram_cas_n, "R4 we inside", {ram_ras_n, ram_cas_n}, 0);
            if (sm && !ram_cas_n)
                check(ram_addr[B-1] == 1'b0, "R3 top line zero", ram_addr[B-1], 0);
            if (sample_stb) begin
                check(!ram_we_n, "R5 stb with we", ram_we_n, 0);
                if (k > 0) check(clk_cnt - last_clk == 9, "R5 period", clk_cnt - last_clk, 9);
                last_clk = clk_cnt;
                check(int'(rd_loc) == exp_loc(k, sm), sm ? "R3 address" : "R2 address",
                      int'(rd_loc), exp_loc(k, sm));
                check(wr_loc == rd_loc, "R8 same location", int'(wr_loc), int'(rd_loc));
                exp_q.push_back(din);
                e = exp_q.pop_front();
                check(dout == e, "R7 delayed bit", dout, e);
                prev_dout = dout;
                din = 1'($urandom);
                k++;
            end else begin
                check(dout == prev_dout, "R6 output held", dout, prev_dout);
            end
        end
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        run_mode(1'b0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule